// File: doc/BRIEF.md
# Speaker Tone Drive Controller

This block drives a one-bit speaker line from three sources under software control. The first is a direct data bit that software flips to build its own pulse train. The second is a square wave from a divisor counter. The third is a gate bit that starts and stops that counter by masking its input-clock enable. All three can act together. Software reaches the block through a small register write port with an address, a data byte and a strobe. A separate `tick_en` input, usually a divided timebase, paces the counter.

The counter holds a divisor of `CNT_W` bits, written one byte at a time. It spends half of the divisor, in ticks, in each output level. A new divisor is picked up only when the counter next reloads, so a period that has already started is never cut short. The registered speaker output is the counter wave ANDed with the data bit. While the gate is low, the wave is held high, so the speaker follows the data bit alone.

Top module: `spk_tone_ctrl`

## Requirements
- R1: After synchronous reset, `spk_out` is 0, both control bits are 0 and the divisor is 0.
- R2: A write to address 0 sets the gate from data bit 0 and the speaker data bit from data bit 1. With the gate at 0, `spk_out` follows the data bit.
- R3: While the gate is 0, the counter keeps its count and its wave output is high.
- R4: With the gate at 1 and `tick_en` high every cycle, the wave toggles every H cycles, where H = divisor >> 1.
- R5: When divisor >> 1 is 0 (divisor 0 or 1), the half period H is 2^(CNT_W-1) ticks.
- R6: The counter advances only in cycles where `tick_en` is 1. With `tick_en` held low, the speaker output does not change.
- R7: A new divisor takes effect at the next reload. The half period already running finishes at the old length.
- R8: `spk_out` is the data bit ANDed with the wave. With the data bit at 0 the speaker stays silent even while the counter runs.
- R9: Address 1 writes the divisor low byte and address 2 writes the high byte. Writes to address 3, and bits 7..2 of a control write, have no effect.
- R10: Direct toggling, counting and gating can all happen in the same run, or the same cycle, and the output matches their combination every cycle.
- R11: `spk_out` is registered. A control write strobed before clock edge k is visible on `spk_out` after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | DATA_W | Register write data |
| tick_en | input | 1 | Counter input-clock enable |
| spk_out | output | 1 | Speaker drive line |

## Verification
A divisor write and a counter reload can land in the same cycle. The bench provokes this by writing a new divisor just after an observed edge of the tone. The half period in flight must keep its old length, and the one after it must take the new length. Control-bit writes and counter toggles can also coincide. Random writes under a random `tick_en` make both collisions frequent, and a cycle-by-cycle model built from the requirements judges every cycle of the output.

// File: rtl/spk_tone_pkg.sv
package spk_tone_pkg;
  localparam int ADDR_CTRL     = 0;
  localparam int ADDR_DIV_BASE = 1;
  localparam int CTRL_GATE_BIT = 0;
  localparam int CTRL_DATA_BIT = 1;

  typedef struct packed {
    logic data;
    logic gate;
  } spk_ctrl_t;
endpackage

// File: rtl/spk_regs.sv
module spk_regs
  import spk_tone_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output spk_ctrl_t         ctrl,
  output logic [CNT_W-1:0]  divisor
);
  localparam int LANES = CNT_W / DATA_W;

  spk_ctrl_t ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_en && wr_addr == ADDR_W'(ADDR_CTRL)) begin
      ctrl_q.gate <= wr_data[CTRL_GATE_BIT];
      ctrl_q.data <= wr_data[CTRL_DATA_BIT];
    end
  end

  assign ctrl = ctrl_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [DATA_W-1:0] byte_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        byte_q <= '0;
      end else if (wr_en && wr_addr == ADDR_W'(ADDR_DIV_BASE + i)) begin
        byte_q <= wr_data;
      end
    end
    assign divisor[i*DATA_W +: DATA_W] = byte_q;
  end
endmodule

// File: rtl/spk_half_counter.sv
module spk_half_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gate,
  input  logic             tick_en,
  input  logic [CNT_W-1:0] divisor,
  output logic [CNT_W-1:0] cnt,
  output logic             wave
);
  localparam logic [CNT_W-1:0] HALF_MAX = {1'b1, {(CNT_W-1){1'b0}}};

  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] cnt_q;
  logic             wave_q;

  always_comb begin
    half = divisor >> 1;
    if (half == '0) half = HALF_MAX;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      wave_q <= 1'b1;
    end else if (!gate) begin
      wave_q <= 1'b1;
    end else if (tick_en) begin
      if (cnt_q == '0) begin
        cnt_q <= half;
      end else if (cnt_q == CNT_W'(1)) begin
        cnt_q  <= half;
        wave_q <= ~wave_q;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign cnt  = cnt_q;
  assign wave = wave_q;
endmodule

// File: rtl/spk_mixer.sv
module spk_mixer (
  input  logic clk,
  input  logic rst,
  input  logic data,
  input  logic gate,
  input  logic wave,
  output logic spk
);
  logic spk_q;

  always_ff @(posedge clk) begin
    if (rst) spk_q <= 1'b0;
    else     spk_q <= data & (gate ? wave : 1'b1);
  end

  assign spk = spk_q;
endmodule

// File: rtl/spk_tone_ctrl.sv
module spk_tone_ctrl
  import spk_tone_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tick_en,
  output logic              spk_out
);
  spk_ctrl_t        ctrl;
  logic [CNT_W-1:0] divisor;
  logic [CNT_W-1:0] cnt_q;
  logic             wave_q;
  logic             gate_q;
  logic             data_q;

  spk_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl(ctrl), .divisor(divisor)
  );

  assign gate_q = ctrl.gate;
  assign data_q = ctrl.data;

  spk_half_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .gate(gate_q), .tick_en(tick_en),
    .divisor(divisor), .cnt(cnt_q), .wave(wave_q)
  );

  spk_mixer u_mix (
    .clk(clk), .rst(rst), .data(data_q), .gate(gate_q),
    .wave(wave_q), .spk(spk_out)
  );
endmodule

// File: rtl/spk_tone_chk.sv
module spk_tone_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_en,
  input logic             spk_out,
  input logic             gate_q,
  input logic             data_q,
  input logic             wave_q,
  input logic [CNT_W-1:0] cnt_q
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !spk_out);

  // R3
  gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(gate_q) |-> $stable(cnt_q));

  // R3
  gate_high_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(gate_q) |-> wave_q);

  // R6
  tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(tick_en) |-> $stable(cnt_q));

  // R4
  toggle_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(gate_q) && (wave_q != $past(wave_q))) |->
      ($past(cnt_q) == CNT_W'(1) && $past(tick_en)));

  // R8
  spk_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
    spk_out |-> $past(data_q));
endmodule

bind spk_tone_ctrl spk_tone_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .spk_out(spk_out),
  .gate_q(gate_q), .data_q(data_q), .wave_q(wave_q), .cnt_q(cnt_q)
);

// File: tb/spk_tone_ctrl_bench.sv
`timescale 1ns/1ps
module spk_tone_ctrl_bench;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic tick_en = 1'b1;
  logic spk_out;

  always #2 clk = ~clk;

  spk_tone_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_spk_tone_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tick_en(tick_en), .spk_out(spk_out)
  );

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;
  string cur_tag = "R1";

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model from the requirements
  logic             m_gate, m_data, m_wave, m_spk;
  logic [CNT_W-1:0] m_div, m_cnt;

  function automatic logic [CNT_W-1:0] half_of(input logic [CNT_W-1:0] d);
    logic [CNT_W-1:0] h;
    h = d >> 1;
    if (h == '0) h = CNT_W'(1) << (CNT_W - 1);
    return h;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_gate <= 0; m_data <= 0; m_div <= '0; m_cnt <= '0; m_wave <= 1; m_spk <= 0;
    end else begin
      m_spk <= m_data & (m_gate ? m_wave : 1'b1);
      if (!m_gate) m_wave <= 1'b1;
      else if (tick_en) begin
        if (m_cnt == '0) m_cnt <= half_of(m_div);
        else if (m_cnt == CNT_W'(1)) begin
          m_cnt <= half_of(m_div);
          m_wave <= ~m_wave;
        end else m_cnt <= m_cnt - 1'b1;
      end
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin m_gate <= wr_data[0]; m_data <= wr_data[1]; end
          2'd1: m_div[7:0] <= wr_data;
          2'd2: m_div[15:8] <= wr_data;
          default: ;
        endcase
      end
    end
  end

  // Edge tracker and per-cycle model compare
  int cyc = 0, last_chg = 0, last_len = 0, n_chg = 0;
  logic prev_spk = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (!rst && spk_out !== prev_spk) begin
      last_len = cyc - last_chg;
      last_chg = cyc;
      n_chg++;
    end
    prev_spk = spk_out;
    if (cmp_on && !done) check(cur_tag, int'(spk_out), int'(m_spk));
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en <= 1'b1; wr_addr <= ADDR_W'(a); wr_data <= DATA_W'(d);
    @(negedge clk);
    wr_en <= 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_chg();
    int n0;
    n0 = n_chg;
    while (n_chg == n0) @(negedge clk);
  endtask

  initial begin
    int n0;
    void'($urandom(32'd4242));
    idle(3);
    // R1: reset state
    check("R1", int'(spk_out), 0);
    @(negedge clk); rst <= 1'b0;
    idle(2);
    check("R1", int'(spk_out), 0);
    cmp_on = 1'b1;

    // R2 / R11: direct bit with gate off, one registered stage
    cur_tag = "R2";
    @(negedge clk);
    wr_en <= 1'b1; wr_addr <= 2'd0; wr_data <= 8'h02;
    @(negedge clk);
    wr_en <= 1'b0;
    check("R11", int'(spk_out), 0);
    @(negedge clk);
    check("R11", int'(spk_out), 1);
    for (int i = 0; i < 6; i++) begin
      wr(0, (i % 2 == 0) ? 8'h00 : 8'h02);
      idle(1);
      check("R2", int'(spk_out), (i % 2 == 0) ? 0 : 1);
    end

    // R4: square wave, divisor 10 -> half 5, divisor 7 -> half 3
    cur_tag = "R4";
    wr(1, 10); wr(2, 0); wr(0, 8'h03);
    wait_chg(); wait_chg(); wait_chg();
    check("R4", last_len, 5);
    wr(1, 7);
    wait_chg(); wait_chg(); wait_chg();
    check("R4", last_len, 3);

    // R8: data bit cleared silences the running tone
    cur_tag = "R8";
    wr(0, 8'h01);
    idle(2);
    n0 = n_chg;
    idle(20);
    check("R8", int'(spk_out), 0);
    check("R8", n_chg, n0);

    // R3: gate off holds wave high, speaker follows data
    cur_tag = "R3";
    wr(0, 8'h02);
    idle(2);
    n0 = n_chg;
    idle(20);
    check("R3", int'(spk_out), 1);
    check("R3", n_chg, n0);

    // R6: tick_en low freezes the counter
    cur_tag = "R6";
    wr(1, 16); wr(0, 8'h03);
    wait_chg(); wait_chg();
    @(negedge clk); tick_en <= 1'b0;
    idle(2);
    n0 = n_chg;
    idle(30);
    check("R6", n_chg, n0);
    @(negedge clk); tick_en <= 1'b1;

    // R7: divisor change lands at the next reload (half 8 -> 20)
    cur_tag = "R7";
    wait_chg(); wait_chg();
    wait_chg();
    wr(1, 40);
    wait_chg();
    check("R7", last_len, 8);
    wait_chg();
    check("R7", last_len, 20);

    // R9: address 3 and upper control bits ignored
    cur_tag = "R9";
    wr(3, 8'hFF);
    wait_chg(); wait_chg();
    check("R9", last_len, 20);
    wr(0, 8'hFD);
    idle(3);
    check("R9", int'(spk_out), 0);
    wr(0, 8'hFF);

    // R5: divisor 1 -> half period 2^(CNT_W-1)
    cur_tag = "R5";
    wr(1, 1);
    for (int k = 0; k < 5 && last_len < 1000; k++) wait_chg();
    check("R5", last_len, 32768);

    // R10: all three methods mixed at random
    cur_tag = "R10";
    wr(1, 6); wr(2, 0);
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      tick_en <= ($urandom % 4) != 0;
      if ($urandom % 6 == 0) begin
        int a;
        a = $urandom % 4;
        wr_en <= 1'b1;
        wr_addr <= ADDR_W'(a);
        if (a == 1) wr_data <= DATA_W'(2 + $urandom % 11);
        else if (a == 2) wr_data <= ($urandom % 10 == 0) ? 8'h01 : 8'h00;
        else wr_data <= DATA_W'($urandom);
      end else begin
        wr_en <= 1'b0;
      end
    end
    @(negedge clk); wr_en <= 1'b0;
    idle(4);

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule